// File: doc/BRIEF.md
# TDM Timeslot Channel-ID Sequencer

The sequencer walks through every byte position of a byte-interleaved telecom bus that carries four STM-1 tributary groups. For each accepted byte it reports the STM group, link and timeslot of that byte, together with the flat channel identifier that a packet-based TDM transport uses to place the byte. A one-cycle valid strobe marks each reported position.

Two bus layouts are supported. In E1 mode each STM carries 63 links of 32 timeslots. In T1 mode each STM carries 84 links of 24 timeslots. The STM index changes fastest, then the link, then the timeslot. The channel identifier is (timeslot × links_per_stm + link) × 4 + stm, so the STM index sits in the least significant position. Both modes span 8064 identifiers, from 0 to 8063, in a 13-bit field.

A frame-start pulse realigns the walk to position zero and samples the mode input. Bytes are consumed only while the enable input is high. Between frame starts the walk wraps and continues on its own.

Top module: `tdm_chid_seq`

## Requirements
- R1: After reset, valid_o, chid_o, stm_o, link_o and ts_o are 0. No byte is reported until the first frame_start_i pulse, whatever en_i does.
- R2: A cycle with frame_start_i high consumes no byte, even if en_i is high. The next consumed byte is reported as stm 0, link 0, timeslot 0, chid 0.
- R3: Each consumed byte advances the position. stm steps 0 to 3 first. When stm wraps, link advances. When link wraps, the timeslot advances.
- R4: With mode 0 (E1), link runs 0 to 62 and the timeslot runs 0 to 31.
- R5: With mode 1 (T1), link runs 0 to 83 and the timeslot runs 0 to 23.
- R6: In E1 mode, chid_o = (ts_o × 63 + link_o) × 4 + stm_o.
- R7: In T1 mode, chid_o = (ts_o × 84 + link_o) × 4 + stm_o.
- R8: Successive reported IDs increase by 1 up to 8063. After that, the walk wraps to position 0 (chid 0) without a frame start.
- R9: While en_i is low, no byte is reported and the position is held.
- R10: t1_mode_i is sampled only in a frame_start_i cycle, where 1 selects T1 and 0 selects E1. A change at any other time has no effect until the next frame start. The sampled mode resets to E1.
- R11: A byte consumed at a clock edge is reported with valid_o high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame alignment pulse; samples the mode |
| en_i | input | 1 | Byte enable; consume one byte per high cycle |
| t1_mode_i | input | 1 | Mode request: 1 = T1, 0 = E1 |
| valid_o | output | 1 | Reported position valid |
| chid_o | output | 13 | Flat channel identifier |
| stm_o | output | 2 | STM group index |
| link_o | output | 7 | Link index within the STM |
| ts_o | output | 5 | Timeslot index |

## Verification
Complete E1 and T1 frames are run past their final byte. This shows that both radices reach their maximum link and timeslot, and that the ID wraps from 8063 to 0 without a frame start. A periodic gap pattern on the enable input separates holding the position from skipping bytes. A mode change without a frame start distinguishes a mode sampled once per frame from one that is followed live. A frame start that arrives together with an enable in the middle of a frame shows that the pulse realigns the walk and does not consume the byte.

// File: rtl/tdm_chid_pkg.sv
package tdm_chid_pkg;
  typedef enum logic {MODE_E1 = 1'b0, MODE_T1 = 1'b1} tdm_mode_e;

  localparam int unsigned DEF_STM_N    = 4;
  localparam int unsigned DEF_E1_LINKS = 63;
  localparam int unsigned DEF_E1_SLOTS = 32;
  localparam int unsigned DEF_T1_LINKS = 84;
  localparam int unsigned DEF_T1_SLOTS = 24;
  localparam int unsigned DEF_CHID_W   = 13;

  // ID_STYLE values
  localparam int unsigned ID_ACCUM = 0;
  localparam int unsigned ID_CALC  = 1;
endpackage

// File: rtl/tdm_wrap_cnt.sv
module tdm_wrap_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/tdm_chid_acc.sv
module tdm_chid_acc #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         wrap_i,
  output logic [W-1:0] id_o
);
  logic [W-1:0] id_q;

  // Positions are visited in ID order, so the ID is a wrapping running count.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_q <= '0;
    else if (clr_i)  id_q <= '0;
    else if (step_i) id_q <= wrap_i ? '0 : id_q + W'(1);
  end

  assign id_o = id_q;
endmodule

// File: rtl/tdm_chid_calc.sv
module tdm_chid_calc #(
  parameter int unsigned STM_N    = 4,
  parameter int unsigned E1_LINKS = 63,
  parameter int unsigned T1_LINKS = 84,
  parameter int unsigned STM_W    = 2,
  parameter int unsigned LINK_W   = 7,
  parameter int unsigned SLOT_W   = 5,
  parameter int unsigned CHID_W   = 13
) (
  input  logic              t1_i,
  input  logic [STM_W-1:0]  stm_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic [SLOT_W-1:0] ts_i,
  output logic [CHID_W-1:0] id_o
);
  logic [CHID_W-1:0] ts_w, row_e1, row_t1, row;

  // Constant-coefficient products only; both reduce to shift-add.
  always_comb begin
    ts_w   = CHID_W'(ts_i);
    row_e1 = ts_w * CHID_W'(E1_LINKS);
    row_t1 = ts_w * CHID_W'(T1_LINKS);
    row    = (t1_i ? row_t1 : row_e1) + CHID_W'(link_i);
    id_o   = row * CHID_W'(STM_N) + CHID_W'(stm_i);
  end
endmodule

// File: rtl/tdm_chid_seq.sv
module tdm_chid_seq
  import tdm_chid_pkg::*;
#(
  parameter int unsigned STM_N    = DEF_STM_N,
  parameter int unsigned E1_LINKS = DEF_E1_LINKS,
  parameter int unsigned E1_SLOTS = DEF_E1_SLOTS,
  parameter int unsigned T1_LINKS = DEF_T1_LINKS,
  parameter int unsigned T1_SLOTS = DEF_T1_SLOTS,
  parameter int unsigned CHID_W   = DEF_CHID_W,
  parameter int unsigned ID_STYLE = ID_ACCUM,
  localparam int unsigned MAX_LINKS = (E1_LINKS > T1_LINKS) ? E1_LINKS : T1_LINKS,
  localparam int unsigned MAX_SLOTS = (E1_SLOTS > T1_SLOTS) ? E1_SLOTS : T1_SLOTS,
  localparam int unsigned STM_W  = (STM_N > 1) ? $clog2(STM_N) : 1,
  localparam int unsigned LINK_W = (MAX_LINKS > 1) ? $clog2(MAX_LINKS) : 1,
  localparam int unsigned SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              en_i,
  input  logic              t1_mode_i,
  output logic              valid_o,
  output logic [CHID_W-1:0] chid_o,
  output logic [STM_W-1:0]  stm_o,
  output logic [LINK_W-1:0] link_o,
  output logic [SLOT_W-1:0] ts_o
);
  localparam logic [STM_W-1:0]  STM_LAST     = STM_W'(STM_N - 1);
  localparam logic [LINK_W-1:0] E1_LINK_LAST = LINK_W'(E1_LINKS - 1);
  localparam logic [LINK_W-1:0] T1_LINK_LAST = LINK_W'(T1_LINKS - 1);
  localparam logic [SLOT_W-1:0] E1_SLOT_LAST = SLOT_W'(E1_SLOTS - 1);
  localparam logic [SLOT_W-1:0] T1_SLOT_LAST = SLOT_W'(T1_SLOTS - 1);

  tdm_mode_e mode_q;
  logic      armed_q;
  logic      step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_E1;
      armed_q <= 1'b0;
    end else if (frame_start_i) begin
      mode_q  <= tdm_mode_e'(t1_mode_i);
      armed_q <= 1'b1;
    end
  end

  // The frame-start cycle only realigns; it never consumes a byte.
  assign step = en_i & armed_q & ~frame_start_i;

  logic [LINK_W-1:0] link_last_val;
  logic [SLOT_W-1:0] slot_last_val;
  assign link_last_val = (mode_q == MODE_T1) ? T1_LINK_LAST : E1_LINK_LAST;
  assign slot_last_val = (mode_q == MODE_T1) ? T1_SLOT_LAST : E1_SLOT_LAST;

  logic [STM_W-1:0]  stm_c;
  logic [LINK_W-1:0] link_c;
  logic [SLOT_W-1:0] ts_c;
  logic stm_last, link_last, ts_last, wrap_all;

  tdm_wrap_cnt #(.W(STM_W)) u_stm_cnt (
    .clk_i, .rst_ni, .clr_i(frame_start_i), .step_i(step),
    .last_i(STM_LAST), .cnt_o(stm_c), .last_o(stm_last)
  );

  tdm_wrap_cnt #(.W(LINK_W)) u_link_cnt (
    .clk_i, .rst_ni, .clr_i(frame_start_i), .step_i(step & stm_last),
    .last_i(link_last_val), .cnt_o(link_c), .last_o(link_last)
  );

  tdm_wrap_cnt #(.W(SLOT_W)) u_slot_cnt (
    .clk_i, .rst_ni, .clr_i(frame_start_i), .step_i(step & stm_last & link_last),
    .last_i(slot_last_val), .cnt_o(ts_c), .last_o(ts_last)
  );

  assign wrap_all = stm_last & link_last & ts_last;

  logic [CHID_W-1:0] id_cur;

  generate
    if (ID_STYLE == ID_ACCUM) begin : g_id_accum
      tdm_chid_acc #(.W(CHID_W)) u_acc (
        .clk_i, .rst_ni, .clr_i(frame_start_i), .step_i(step),
        .wrap_i(wrap_all), .id_o(id_cur)
      );
    end else begin : g_id_calc
      tdm_chid_calc #(
        .STM_N(STM_N), .E1_LINKS(E1_LINKS), .T1_LINKS(T1_LINKS),
        .STM_W(STM_W), .LINK_W(LINK_W), .SLOT_W(SLOT_W), .CHID_W(CHID_W)
      ) u_calc (
        .t1_i(mode_q == MODE_T1), .stm_i(stm_c), .link_i(link_c),
        .ts_i(ts_c), .id_o(id_cur)
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      chid_o  <= '0;
      stm_o   <= '0;
      link_o  <= '0;
      ts_o    <= '0;
    end else begin
      valid_o <= step;
      if (step) begin
        chid_o <= id_cur;
        stm_o  <= stm_c;
        link_o <= link_c;
        ts_o   <= ts_c;
      end
    end
  end
endmodule

// File: rtl/tdm_chid_seq_chk.sv
module tdm_chid_seq_chk #(
  parameter int unsigned STM_N    = 4,
  parameter int unsigned E1_LINKS = 63,
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned T1_LINKS = 84,
  parameter int unsigned T1_SLOTS = 24,
  parameter int unsigned CHID_W   = 13,
  parameter int unsigned STM_W    = 2,
  parameter int unsigned LINK_W   = 7,
  parameter int unsigned SLOT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic              en_i,
  input logic              valid_o,
  input logic [CHID_W-1:0] chid_o,
  input logic [STM_W-1:0]  stm_o,
  input logic [LINK_W-1:0] link_o,
  input logic [SLOT_W-1:0] ts_o,
  input logic              mode_i
);
  localparam int unsigned ID_MAX = E1_LINKS * E1_SLOTS * STM_N - 1;

  int unsigned n_links, n_slots, exp_id;
  always_comb begin
    n_links = mode_i ? T1_LINKS : E1_LINKS;
    n_slots = mode_i ? T1_SLOTS : E1_SLOTS;
    exp_id  = (32'(ts_o) * n_links + 32'(link_o)) * STM_N + 32'(stm_o);
  end

  logic              seen_fs, have_prev;
  logic [CHID_W-1:0] prev_id, next_id;
  assign next_id = (32'(prev_id) == ID_MAX) ? '0 : prev_id + CHID_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_fs   <= 1'b0;
      have_prev <= 1'b0;
      prev_id   <= '0;
    end else if (frame_start_i) begin
      seen_fs   <= 1'b1;
      have_prev <= 1'b0;
    end else if (valid_o) begin
      have_prev <= 1'b1;
      prev_id   <= chid_o;
    end
  end

  a_r1_no_report_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_fs |-> !valid_o);
  a_r2_fs_consumes_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !valid_o);
  a_r2_first_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !have_prev) |-> (chid_o == '0));
  a_r4_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(stm_o) < STM_N && 32'(link_o) < n_links && 32'(ts_o) < n_slots));
  a_r6_r7_id_formula: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(chid_o) == exp_id));
  a_r8_consecutive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && have_prev) |-> (chid_o == next_id));
  a_r9_idle_no_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  a_r10_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(mode_i));
endmodule

bind tdm_chid_seq tdm_chid_seq_chk #(
  .STM_N(STM_N), .E1_LINKS(E1_LINKS), .E1_SLOTS(E1_SLOTS),
  .T1_LINKS(T1_LINKS), .T1_SLOTS(T1_SLOTS), .CHID_W(CHID_W),
  .STM_W(STM_W), .LINK_W(LINK_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i, .rst_ni, .frame_start_i, .en_i, .valid_o, .chid_o,
  .stm_o, .link_o, .ts_o, .mode_i(mode_q)
);

// File: tb/tdm_chid_seq_tb.sv
module tdm_chid_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 8064;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, en = 1'b0, t1 = 1'b0;
  logic        valid;
  logic [12:0] chid;
  logic [1:0]  stm;
  logic [6:0]  link;
  logic [4:0]  ts;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_chid_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .en_i(en), .t1_mode_i(t1),
    .valid_o(valid), .chid_o(chid), .stm_o(stm), .link_o(link), .ts_o(ts)
  );

  typedef struct {int stm; int link; int ts; int chid; int mode;} item_t;
  item_t exp_q[$];
  string tag_q[$];

  int checks = 0, bad = 0;
  bit done = 0, mon_on = 0, exp_fire = 0;
  int m_mode = 0, m_stm = 0, m_link = 0, m_ts = 0, m_armed = 0;
  int accepted = 0;
  int max_link[2] = '{0, 0};
  int max_ts[2]   = '{0, 0};
  int max_id[2]   = '{0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // Driver: drive at negedge, push expected item for each consumed byte.
  task automatic drive(input logic e, input logic f, input logic m, input string tag);
    item_t it;
    int nl, ns;
    @(negedge clk);
    en = e; fs = f; t1 = m;
    exp_fire = 0;
    if (f) begin
      m_mode = int'(m); m_stm = 0; m_link = 0; m_ts = 0; m_armed = 1;
    end else if (e && m_armed == 1) begin
      nl = (m_mode == 1) ? 84 : 63;
      ns = (m_mode == 1) ? 24 : 32;
      it.stm = m_stm; it.link = m_link; it.ts = m_ts; it.mode = m_mode;
      it.chid = (m_ts * nl + m_link) * 4 + m_stm;
      exp_q.push_back(it);
      tag_q.push_back(tag);
      exp_fire = 1;
      accepted++;
      m_stm++;
      if (m_stm == 4) begin
        m_stm = 0; m_link++;
        if (m_link == nl) begin
          m_link = 0; m_ts++;
          if (m_ts == ns) m_ts = 0;
        end
      end
    end
  endtask

  // Monitor: sample just after the edge, compare against the queue.
  always @(posedge clk) begin
    item_t it;
    string tg;
    #1;
    if (mon_on) begin
      chk(valid == exp_fire, "R11/R9/R1 valid timing", int'(valid), int'(exp_fire));
      if (valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected valid", 1, 0);
        end else begin
          it = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(int'(chid) == it.chid, {tg, " chid"}, int'(chid), it.chid);
          chk(int'(stm) == it.stm && int'(link) == it.link && int'(ts) == it.ts,
              {tg, " position"}, {int'(ts), int'(link), int'(stm)} == 0 ? 0 :
              int'(ts) * 10000 + int'(link) * 10 + int'(stm),
              it.ts * 10000 + it.link * 10 + it.stm);
          if (int'(link) > max_link[it.mode]) max_link[it.mode] = int'(link);
          if (int'(ts) > max_ts[it.mode]) max_ts[it.mode] = int'(ts);
          if (int'(chid) > max_id[it.mode]) max_id[it.mode] = int'(chid);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int start;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    chk(chid == 0 && stm == 0 && link == 0 && ts == 0, "R1 outputs after reset",
        int'(chid), 0);
    mon_on = 1;

    // R1: enable without frame start reports nothing
    for (int i = 0; i < 12; i++) drive(1, 0, 0, "R1");
    chk(accepted == 0, "R1 no bytes before frame start", accepted, 0);

    // E1 frame with gaps, past the wrap
    drive(0, 1, 0, "R2");
    start = accepted;
    for (int i = 0; accepted - start < FRAME + 40; i++)
      drive((i % 7) != 3, 0, 0, "R3/R4/R6/R8/R9");

    // R10: mode request without frame start is ignored
    for (int i = 0; i < 100; i++) drive(1, 0, 1, "R10");

    // T1 frame; frame start together with enable consumes no byte (R2)
    drive(1, 1, 1, "R2");
    start = accepted;
    for (int i = 0; accepted - start < FRAME + 20; i++)
      drive((i % 5) != 0, 0, 1, "R3/R5/R7/R8/R9");

    // R2: mid-frame realignment back to E1
    for (int i = 0; i < 50; i++) drive(1, 0, 0, "R10");
    drive(1, 1, 0, "R2");
    for (int i = 0; i < 30; i++) drive(1, 0, 0, "R2/R6");

    for (int i = 0; i < 4; i++) drive(0, 0, 0, "R9");

    chk(max_link[0] == 62, "R4 max E1 link", max_link[0], 62);
    chk(max_ts[0] == 31, "R4 max E1 timeslot", max_ts[0], 31);
    chk(max_link[1] == 83, "R5 max T1 link", max_link[1], 83);
    chk(max_ts[1] == 23, "R5 max T1 timeslot", max_ts[1], 23);
    chk(max_id[0] == 8063, "R8 max E1 id", max_id[0], 8063);
    chk(max_id[1] == 8063, "R8 max T1 id", max_id[1], 8063);
    chk(exp_q.size() == 0, "R11 all expected bytes reported", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule